// File: doc/BRIEF.md
# Edge-Latched 1K x 1 Dynamic RAM Functional Model

This block is a synthesizable, clock-based model of a one-bit-wide memory of 1024 cells. The cells are arranged as 32 rows by 32 columns. A cycle opens when chip enable rises. The address present at that moment is captured in an internal latch and then used for the rest of the cycle. Write enable is not latched; it acts as a level throughout the cycle. A single chip-enable pulse can therefore hold a plain read, a plain write, or a read followed by a write to the same cell (read-modify-write).

All inputs are sampled on the rising edge of the system clock. The rising edge of chip enable is found by comparing the input with a registered copy of it. A refresh input exists so that the block can be dropped in where a refresh strobe is routed. Stored bits never decay in this model, so refresh has no functional effect.

The read data leaves as a one-bit stream with a valid flag and no ready. The output is a sampled view of the cell, so there is nothing to hold back. A consumer that cannot take a bit simply lets the next cycle's value replace it. When the flag is low, the data bit is forced to 0.

Top module: `dram1k_model`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are 0 and every cell reads back as 0.
- R2: The address on `addr` is captured at the clock edge where `ce` is sampled high after being sampled low. Later changes of `addr` within the same `ce` pulse have no effect on which cell is read or written.
- R3: Each of the 1024 addresses holds its own bit. `addr[4:0]` picks the row and `addr[9:5]` picks the column, and writing one address leaves every other address unchanged.
- R4: At every clock edge where `ce` and `we` are both sampled high, `wr_data` is stored into the cell of the current cycle's address. At the opening edge, that address is the one on `addr`.
- R5: At an edge where `ce` is high, `we` is low and no write has yet occurred in the pulse, one clock later `rd_valid` is 1 and `rd_data` equals the cell's content.
- R6: Once `we` has been sampled high in a `ce` pulse, `rd_valid` stays 0 for the rest of that pulse, even if `we` returns low.
- R7: One clock after `ce` is sampled low, `rd_valid` is 0 and `rd_data` is 0.
- R8: Read-modify-write works within one pulse. The original bit is read first and the new bit is then written. The next pulse reads the new bit.
- R9: `refresh` has no effect on stored bits or on the outputs.
- R10: If `we` is already high at the opening edge, the cycle is a write: the bit is stored and `rd_valid` never rises in that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Chip enable; its rising edge opens a cycle |
| we | input | 1 | Write enable, level-sensitive |
| addr | input | 10 | Cell address; [4:0] row, [9:5] column |
| wr_data | input | 1 | Bit to write |
| refresh | input | 1 | Refresh strobe, functionally ignored |
| rd_data | output | 1 | Read bit, 0 when not valid |
| rd_valid | output | 1 | Read bit is meaningful |

## Verification
Every output is one register away from its inputs. A read sampled at edge k, or the drop of `rd_valid` after `ce` or `we` changes, appears right after edge k. A write sampled at edge k is visible to a read sampled at edge k+1 or later. The bench drives inputs on the falling edge and checks outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. A reference array in the bench is updated at the same points as the writes it mirrors.

// File: rtl/dram1k_pkg.sv
package dram1k_pkg;
  localparam int unsigned ROW_BITS = 5;
  localparam int unsigned COL_BITS = 5;
  localparam int unsigned ADDR_W   = ROW_BITS + COL_BITS;
  localparam int unsigned N_ROWS   = 1 << ROW_BITS;
  localparam int unsigned N_COLS   = 1 << COL_BITS;

  typedef logic [ROW_BITS-1:0] row_t;
  typedef logic [COL_BITS-1:0] col_t;

  typedef struct packed {
    col_t col;
    row_t row;
  } cell_addr_t;
endpackage

// File: rtl/dram1k_ctrl.sv
module dram1k_ctrl
  import dram1k_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  logic       we,
  input  cell_addr_t addr,
  output cell_addr_t cyc_addr,
  output logic       wr_en,
  output logic       rd_en
);
  logic       ce_q;
  logic       wrote_q;
  logic       opening;
  logic       wrote_eff;
  cell_addr_t addr_lat;

  assign opening   = ce & ~ce_q;
  assign wrote_eff = wrote_q & ~opening;
  assign cyc_addr  = opening ? addr : addr_lat;
  assign wr_en     = ce & we;
  assign rd_en     = ce & ~we & ~wrote_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q     <= 1'b0;
      wrote_q  <= 1'b0;
      addr_lat <= '0;
    end else begin
      ce_q    <= ce;
      wrote_q <= ce & (wrote_eff | we);
      if (opening) addr_lat <= addr;
    end
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && ce_q) |=> $stable(addr_lat));
endmodule

// File: rtl/dram1k_array.sv
module dram1k_array
  import dram1k_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cell_addr_t cyc_addr,
  input  logic       wr_en,
  input  logic       wr_data,
  output logic       rd_bit
);
  logic [N_COLS-1:0] cells [N_ROWS];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cells[r] <= '0;
      end else if (wr_en && cyc_addr.row == row_t'(r)) begin
        cells[r][cyc_addr.col] <= wr_data;
      end
    end
  end

  assign rd_bit = cells[cyc_addr.row][cyc_addr.col];

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cells[$past(cyc_addr.row)][$past(cyc_addr.col)] == $past(wr_data));
endmodule

// File: rtl/dram1k_out.sv
module dram1k_out (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic we,
  input  logic rd_en,
  input  logic rd_bit,
  output logic rd_data,
  output logic rd_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en & rd_bit;
    end
  end

  // R7
  ce_low_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !rd_valid && !rd_data);
  // R6
  we_kills_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !rd_valid);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !rd_data);
endmodule

// File: rtl/dram1k_model.sv
module dram1k_model
  import dram1k_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_data,
  input  logic              refresh,
  output logic              rd_data,
  output logic              rd_valid
);
  cell_addr_t cyc_addr;
  logic       wr_en;
  logic       rd_en;
  logic       rd_bit;
  logic       unused_refresh;

  assign unused_refresh = refresh;

  dram1k_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(cell_addr_t'(addr)),
    .cyc_addr(cyc_addr), .wr_en(wr_en), .rd_en(rd_en)
  );

  dram1k_array array_i (
    .clk(clk), .rst_n(rst_n), .cyc_addr(cyc_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_bit(rd_bit)
  );

  dram1k_out out_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .rd_en(rd_en),
    .rd_bit(rd_bit), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/dram1k_model_tb.sv
module dram1k_model_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0;
  logic       we = 1'b0;
  logic [9:0] addr = '0;
  logic       wr_data = 1'b0;
  logic       refresh = 1'b0;
  logic       rd_data;
  logic       rd_valid;

  int checks = 0;
  int errors = 0;
  logic ref_mem [1024];

  always #5 clk = ~clk;

  dram1k_model dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
    .wr_data(wr_data), .refresh(refresh), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic exp_read(input logic [9:0] a);
    return ref_mem[a];
  endfunction

  task automatic chk(input string req, input logic v, input logic d,
                     input logic ev, input logic ed);
    checks++;
    if (v !== ev || d !== ed) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%0b expected valid=%0b data=%0b",
               req, v, d, ev, ed);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic close_pulse();
    ce = 1'b0; we = 1'b0; addr = '0;
    step();
    chk("R7", rd_valid, rd_data, 1'b0, 1'b0);
  endtask

  task automatic do_read(input logic [9:0] a, input string req);
    ce = 1'b1; we = 1'b0; addr = a;
    step();
    chk(req, rd_valid, rd_data, 1'b1, exp_read(a));
    addr = ~a;
    step();
    chk("R2", rd_valid, rd_data, 1'b1, exp_read(a));
    close_pulse();
  endtask

  task automatic do_write(input logic [9:0] a, input logic d);
    ce = 1'b1; we = 1'b1; addr = a; wr_data = d;
    step();
    ref_mem[a] = d;
    chk("R10", rd_valid, rd_data, 1'b0, 1'b0);
    we = 1'b0; addr = ~a; wr_data = ~d;
    step();
    chk("R6", rd_valid, rd_data, 1'b0, 1'b0);
    close_pulse();
  endtask

  task automatic do_rmw(input logic [9:0] a, input logic d);
    ce = 1'b1; we = 1'b0; addr = a;
    step();
    chk("R8", rd_valid, rd_data, 1'b1, exp_read(a));
    addr = ~a; we = 1'b1; wr_data = d;
    step();
    ref_mem[a] = d;
    chk("R6", rd_valid, rd_data, 1'b0, 1'b0);
    we = 1'b0;
    step();
    chk("R6", rd_valid, rd_data, 1'b0, 1'b0);
    close_pulse();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: valid=%0b data=%0b expected run to end", rd_valid, rd_data);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd7091;
    void'($urandom(seed));
    for (int i = 0; i < 1024; i++) ref_mem[i] = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1
    chk("R1", rd_valid, rd_data, 1'b0, 1'b0);
    do_read(10'd0, "R1");
    do_read(10'h3FF, "R1");

    // R3: row-neighbour and column-neighbour stay independent
    do_write(10'h021, 1'b1);
    do_read(10'h021, "R4");
    do_read(10'h001, "R3");
    do_read(10'h020, "R3");
    do_read(10'h022, "R3");
    do_read(10'h041, "R3");

    // R8
    do_rmw(10'h155, 1'b1);
    do_read(10'h155, "R8");
    do_rmw(10'h155, 1'b0);
    do_read(10'h155, "R8");

    // R9: refresh toggling during idle and during a read
    do_write(10'h2AA, 1'b1);
    refresh = 1'b1;
    step();
    chk("R9", rd_valid, rd_data, 1'b0, 1'b0);
    do_read(10'h2AA, "R9");
    refresh = 1'b0;
    do_read(10'h2AA, "R9");

    // R5: long read pulse stays valid over several cycles
    ce = 1'b1; we = 1'b0; addr = 10'h2AA;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R5", rd_valid, rd_data, 1'b1, 1'b1);
      addr = 10'(k);
    end
    close_pulse();

    // Randomised mix
    for (int n = 0; n < 400; n++) begin
      logic [9:0] a;
      logic d;
      int op;
      a = 10'($urandom);
      d = 1'($urandom);
      op = $urandom_range(0, 2);
      refresh = 1'($urandom);
      if (op == 0) do_read(a, "R5");
      else if (op == 1) do_write(a, d);
      else do_rmw(a, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule